// File: doc/BRIEF.md
# Link Integrity and Polarity Monitor

This block is the per-port supervisor behind a 10BASE-T receiver. Pulse detection logic in front of it reports each received link test pulse as either correctly polarised or inverted (relative to the present correction setting). The frame receiver reports each frame end as either normal or carrying a reversed start-of-idle. From these strobes and a one-millisecond tick, the monitor decides whether the cable is alive. It gates the port transmitter accordingly and drives the control that swaps the receive pair when the wiring is crossed.

The link is declared lost after a long silence and regained after a short burst of valid activity. A link pulse only counts when it arrives inside a legal spacing window after the pulse before it. Polarity correction flips on a run of inverted pulses or on a run of reversed frame ends. The correction is dropped again once the port has sat in link fail long enough. When link testing is switched off, the port is held up and only frames steer the polarity.

Top module: `link_polarity_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `link_ok`, `tx_enable` and `pol_invert` are all 0; the port starts in link fail.
- R2: A pulse strobe is valid only when the number of `ms_tick` pulses since the previous pulse strobe (of either kind) lies in 5..30. The count saturates, so the first pulse after reset is invalid. Invalid pulses cause no link activity and do not touch the polarity counters, but every pulse restarts the spacing count.
- R3: In link fail, the third activity event raises `link_ok` on the following clock edge. An activity event is a valid correct pulse, a normal frame end or a reversed frame end.
- R4: In link up, 100 consecutive `ms_tick` pulses with no activity drop `link_ok` at the edge of the 100th tick. Activity in the same cycle as a tick restarts the count. `tx_enable` always equals `link_ok`.
- R5: Sixteen valid inverted pulses with no valid correct pulse between them toggle `pol_invert`. A valid correct pulse clears the run. Inverted pulses are not link activity.
- R6: Four reversed frame ends with no normal frame end between them toggle `pol_invert`. A normal frame end clears that run. Any toggle clears both runs.
- R7: In link fail, 112 consecutive ticks without activity (counted from entry to link fail or from the last activity) force `pol_invert` to 0 and clear both runs.
- R8: With `link_test_en` low, `link_ok` and `tx_enable` are 1 from the next edge on, pulse strobes are ignored, and frame ends still drive R6. Re-enabling resumes in link up with a fresh silence count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| link_test_en | input | 1 | 1 enables link integrity testing |
| pulse_ok | input | 1 | Link pulse received with correct polarity |
| pulse_inv | input | 1 | Link pulse received inverted |
| frame_end_ok | input | 1 | Frame ended with normal start-of-idle |
| frame_end_rev | input | 1 | Frame ended with reversed start-of-idle |
| link_ok | output | 1 | Link up |
| tx_enable | output | 1 | Transmitter enable |
| pol_invert | output | 1 | Receive polarity swap control |

## Verification
The bench probes the spacing window at both of its sides: a pulse three ticks after the previous one, and a pulse after the count has saturated. A design that took either as valid would bring the link up early. The silence timeout is checked one tick before and exactly at the hundredth tick, and the polarity revert at tick 111 and tick 112; an off-by-one counter shows up as a flag changing a tick early or late. The runs are checked with an interrupting correct pulse or normal frame end at count fifteen or three. A design that failed to clear the run would flip on the next strobe instead of needing a full new run. With testing disabled, a burst of inverted pulses must leave polarity alone while reversed frames still flip it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic {
        LNK_DOWN = 1'b0,
        LNK_UP   = 1'b1
    } link_state_e;

    typedef struct packed {
        logic good;
        logic inv;
    } pulse_qual_t;

    function automatic logic in_window(input int unsigned gap,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (gap >= lo) && (gap <= hi);
    endfunction

endpackage

// File: rtl/lpm_pulse_gate.sv
module lpm_pulse_gate
    import lpm_pkg::*;
#(
    parameter int unsigned MIN_GAP = 5,
    parameter int unsigned MAX_GAP = 30
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        tick,
    input  logic        pulse_ok,
    input  logic        pulse_inv,
    output pulse_qual_t qual
);
    localparam int unsigned GW = $clog2(MAX_GAP + 2);
    localparam logic [GW-1:0] SAT = GW'(MAX_GAP + 1);

    logic [GW-1:0] gap;
    logic          win;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= SAT;
        end else if (pulse_ok || pulse_inv) begin
            gap <= '0;
        end else if (tick && (gap != SAT)) begin
            gap <= gap + 1'b1;
        end
    end

    always_comb begin
        win      = in_window(int'(gap), MIN_GAP, MAX_GAP);
        qual.good = en && pulse_ok && win;
        qual.inv  = en && pulse_inv && !pulse_ok && win;
    end

    assert_one_kind_R2: assert property (@(posedge clk) disable iff (rst)
        !(qual.good && qual.inv));

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(qual.good || qual.inv));

endmodule

// File: rtl/lpm_link_fsm.sv
module lpm_link_fsm
    import lpm_pkg::*;
#(
    parameter int unsigned LOSS_MS  = 100,
    parameter int unsigned POL_MS   = 112,
    parameter int unsigned WAKE_CNT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic act,
    output logic link_ok,
    output logic pol_reset
);
    localparam int unsigned IW = $clog2(LOSS_MS + 1);
    localparam int unsigned PW = $clog2(POL_MS + 1);
    localparam int unsigned WW = $clog2(WAKE_CNT + 1);

    link_state_e   st;
    logic [IW-1:0] idle;
    logic [PW-1:0] ptmr;
    logic [WW-1:0] wake;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LNK_DOWN;
            idle <= '0;
            ptmr <= '0;
            wake <= '0;
        end else if (!en) begin
            st   <= LNK_UP;
            idle <= '0;
            ptmr <= '0;
            wake <= '0;
        end else begin
            case (st)
                LNK_UP: begin
                    if (act) begin
                        idle <= '0;
                    end else if (tick) begin
                        if (idle == IW'(LOSS_MS - 1)) begin
                            st   <= LNK_DOWN;
                            idle <= '0;
                            ptmr <= '0;
                            wake <= '0;
                        end else begin
                            idle <= idle + 1'b1;
                        end
                    end
                end
                default: begin
                    if (act) begin
                        ptmr <= '0;
                        if (wake == WW'(WAKE_CNT - 1)) begin
                            st   <= LNK_UP;
                            wake <= '0;
                            idle <= '0;
                        end else begin
                            wake <= wake + 1'b1;
                        end
                    end else if (tick && (ptmr != PW'(POL_MS))) begin
                        ptmr <= ptmr + 1'b1;
                    end
                end
            endcase
        end
    end

    assign link_ok   = (st == LNK_UP);
    assign pol_reset = en && (st == LNK_DOWN) && !act && tick && (ptmr == PW'(POL_MS - 1));

    assert_fall_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(link_ok) |-> ($past(tick) && !$past(act)));

    assert_rise_on_act_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(link_ok) |-> ($past(act) || !$past(en)));

    assert_up_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> link_ok);

endmodule

// File: rtl/lpm_polarity.sv
module lpm_polarity #(
    parameter int unsigned INV_LIMIT = 16,
    parameter int unsigned REV_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic valid_good,
    input  logic valid_inv,
    input  logic frame_ok,
    input  logic frame_rev,
    input  logic pol_reset,
    output logic invert
);
    localparam int unsigned ICW = $clog2(INV_LIMIT + 1);
    localparam int unsigned RCW = $clog2(REV_LIMIT + 1);

    logic [ICW-1:0] icnt, icnt_n;
    logic [RCW-1:0] rcnt, rcnt_n;
    logic           flip;

    always_comb begin
        if (valid_good)     icnt_n = '0;
        else if (valid_inv) icnt_n = icnt + 1'b1;
        else                icnt_n = icnt;
        if (frame_rev)      rcnt_n = rcnt + 1'b1;
        else if (frame_ok)  rcnt_n = '0;
        else                rcnt_n = rcnt;
        flip = (icnt_n == ICW'(INV_LIMIT)) || (rcnt_n == RCW'(REV_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (rst || pol_reset) begin
            invert <= 1'b0;
            icnt   <= '0;
            rcnt   <= '0;
        end else if (flip) begin
            invert <= !invert;
            icnt   <= '0;
            rcnt   <= '0;
        end else begin
            icnt <= icnt_n;
            rcnt <= rcnt_n;
        end
    end

    assert_flip_cause_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(invert) |-> ($past(valid_inv) || $past(frame_rev) || $past(pol_reset)));

    assert_revert_R7: assert property (@(posedge clk) disable iff (rst)
        pol_reset |=> !invert);

    assert_good_no_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_good && !frame_rev && !pol_reset) |=> $stable(invert));

endmodule

// File: rtl/link_polarity_monitor.sv
module link_polarity_monitor
    import lpm_pkg::*;
#(
    parameter int unsigned MIN_GAP   = 5,
    parameter int unsigned MAX_GAP   = 30,
    parameter int unsigned LOSS_MS   = 100,
    parameter int unsigned POL_MS    = 112,
    parameter int unsigned WAKE_CNT  = 3,
    parameter int unsigned INV_LIMIT = 16,
    parameter int unsigned REV_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic link_test_en,
    input  logic pulse_ok,
    input  logic pulse_inv,
    input  logic frame_end_ok,
    input  logic frame_end_rev,
    output logic link_ok,
    output logic tx_enable,
    output logic pol_invert
);
    pulse_qual_t qual;
    logic        activity;
    logic        pol_reset;

    lpm_pulse_gate #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) gate_i (
        .clk(clk), .rst(rst), .en(link_test_en), .tick(ms_tick),
        .pulse_ok(pulse_ok), .pulse_inv(pulse_inv), .qual(qual)
    );

    assign activity = qual.good || frame_end_ok || frame_end_rev;

    lpm_link_fsm #(.LOSS_MS(LOSS_MS), .POL_MS(POL_MS), .WAKE_CNT(WAKE_CNT)) fsm_i (
        .clk(clk), .rst(rst), .en(link_test_en), .tick(ms_tick),
        .act(activity), .link_ok(link_ok), .pol_reset(pol_reset)
    );

    lpm_polarity #(.INV_LIMIT(INV_LIMIT), .REV_LIMIT(REV_LIMIT)) pol_i (
        .clk(clk), .rst(rst), .valid_good(qual.good), .valid_inv(qual.inv),
        .frame_ok(frame_end_ok), .frame_rev(frame_end_rev),
        .pol_reset(pol_reset), .invert(pol_invert)
    );

    assign tx_enable = link_ok;

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!link_ok && !pol_invert));

endmodule

// File: tb/link_polarity_monitor_tb_top.sv
module link_polarity_monitor_tb_top;
    localparam int GAP_LO = 5, GAP_HI = 30, GAP_SAT = 31;
    localparam int LOSS = 100, POLT = 112, WAKE = 3, ILIM = 16, RLIM = 4;

    logic clk = 0, rst = 1;
    logic ms_tick = 0, link_test_en = 1, pulse_ok = 0, pulse_inv = 0;
    logic frame_end_ok = 0, frame_end_rev = 0;
    logic link_ok, tx_enable, pol_invert;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    link_polarity_monitor dut_i (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .link_test_en(link_test_en),
        .pulse_ok(pulse_ok), .pulse_inv(pulse_inv), .frame_end_ok(frame_end_ok),
        .frame_end_rev(frame_end_rev), .link_ok(link_ok), .tx_enable(tx_enable),
        .pol_invert(pol_invert)
    );

    // reference model
    int  m_gap, m_idle, m_wake, m_pt, m_icnt, m_rcnt;
    bit  m_up, m_inv, vg, vi, act, pr, win;

    always @(posedge clk) begin
        if (rst) begin
            m_gap = GAP_SAT; m_up = 0; m_idle = 0; m_wake = 0; m_pt = 0;
            m_icnt = 0; m_rcnt = 0; m_inv = 0;
        end else begin
            win = (m_gap >= GAP_LO) && (m_gap <= GAP_HI);
            vg  = link_test_en && pulse_ok && win;
            vi  = link_test_en && pulse_inv && !pulse_ok && win;
            if (pulse_ok || pulse_inv) m_gap = 0;
            else if (ms_tick && m_gap < GAP_SAT) m_gap++;
            act = vg || frame_end_ok || frame_end_rev;
            pr  = 0;
            if (!link_test_en) begin
                m_up = 1; m_idle = 0; m_pt = 0; m_wake = 0;
            end else if (m_up) begin
                if (act) m_idle = 0;
                else if (ms_tick) begin
                    m_idle++;
                    if (m_idle == LOSS) begin m_up = 0; m_idle = 0; m_pt = 0; m_wake = 0; end
                end
            end else begin
                if (act) begin
                    m_pt = 0; m_wake++;
                    if (m_wake == WAKE) begin m_up = 1; m_wake = 0; m_idle = 0; end
                end else if (ms_tick && m_pt < POLT) begin
                    m_pt++;
                    if (m_pt == POLT) pr = 1;
                end
            end
            if (pr) begin
                m_inv = 0; m_icnt = 0; m_rcnt = 0;
            end else begin
                if (vg) m_icnt = 0; else if (vi) m_icnt++;
                if (frame_end_rev) m_rcnt++; else if (frame_end_ok) m_rcnt = 0;
                if (m_icnt == ILIM || m_rcnt == RLIM) begin
                    m_inv = !m_inv; m_icnt = 0; m_rcnt = 0;
                end
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R1..R8 all observed here)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 model link_ok", int'(link_ok), int'(m_up));
            check("R4 model tx_enable", int'(tx_enable), int'(m_up));
            check("R5 model pol_invert", int'(pol_invert), int'(m_inv));
        end
    end

    task automatic step(input bit t, input bit g, input bit i, input bit fo, input bit fr);
        ms_tick = t; pulse_ok = g; pulse_inv = i; frame_end_ok = fo; frame_end_rev = fr;
        @(negedge clk);
        ms_tick = 0; pulse_ok = 0; pulse_inv = 0; frame_end_ok = 0; frame_end_rev = 0;
    endtask

    task automatic ms(input int n);
        for (int k = 0; k < n; k++) begin
            step(1, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1;
        repeat (4) @(negedge clk);
        check("R1 reset link_ok", int'(link_ok), 0);
        check("R1 reset pol_invert", int'(pol_invert), 0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset tx_enable", int'(tx_enable), 0);

        // R2: saturated, too-early and too-late pulses are not activity
        step(0, 1, 0, 0, 0);          // saturated gap -> invalid
        ms(3);  step(0, 1, 0, 0, 0);  // gap 3 -> invalid
        ms(40); step(0, 1, 0, 0, 0);  // gap saturated -> invalid
        check("R2 invalid pulses keep link down", int'(link_ok), 0);

        // R3: three valid pulses at gap 10
        ms(10); step(0, 1, 0, 0, 0);
        ms(10); step(0, 1, 0, 0, 0);
        check("R3 two events not enough", int'(link_ok), 0);
        ms(10); step(0, 1, 0, 0, 0);
        check("R3 third event raises link", int'(link_ok), 1);

        // R4: silence timeout
        ms(LOSS - 1);
        check("R4 up at tick 99", int'(link_ok), 1);
        ms(1);
        check("R4 down at tick 100", int'(link_ok), 0);
        check("R4 tx_enable follows", int'(tx_enable), 0);

        // R3 by frames
        step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0); step(0, 0, 0, 1, 0);
        check("R3 frames raise link", int'(link_ok), 1);

        // R5: inverted pulse runs
        step(0, 0, 1, 0, 0);          // spacer, saturated gap
        for (int k = 0; k < ILIM - 1; k++) begin ms(6); step(0, 0, 1, 0, 0); end
        check("R5 fifteen inverted no flip", int'(pol_invert), 0);
        ms(6); step(0, 1, 0, 0, 0);   // correct pulse clears run
        for (int k = 0; k < ILIM - 1; k++) begin ms(6); step(0, 0, 1, 0, 0); end
        check("R5 run cleared by good pulse", int'(pol_invert), 0);
        ms(6); step(0, 0, 1, 0, 0);
        check("R5 sixteenth inverted flips", int'(pol_invert), 1);

        // R6: reversed frame runs
        step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
        check("R6 normal end clears run", int'(pol_invert), 1);
        step(0, 0, 0, 0, 1);
        check("R6 fourth reversed flips", int'(pol_invert), 0);
        for (int k = 0; k < RLIM; k++) step(0, 0, 0, 0, 1);
        check("R6 flips again", int'(pol_invert), 1);

        // R7: polarity revert in link fail
        ms(LOSS);
        check("R7 link lost", int'(link_ok), 0);
        ms(POLT - 1);
        check("R7 invert held at 111", int'(pol_invert), 1);
        ms(1);
        check("R7 invert cleared at 112", int'(pol_invert), 0);

        // R8: link testing disabled
        link_test_en = 0;
        @(negedge clk);
        check("R8 link forced up", int'(link_ok), 1);
        ms(150);
        check("R8 stays up through silence", int'(tx_enable), 1);
        for (int k = 0; k < 20; k++) begin ms(6); step(0, 0, 1, 0, 0); end
        check("R8 inverted pulses ignored", int'(pol_invert), 0);
        for (int k = 0; k < RLIM; k++) step(0, 0, 0, 0, 1);
        check("R8 frames still flip", int'(pol_invert), 1);
        link_test_en = 1;
        @(negedge clk);
        ms(LOSS - 1);
        check("R8 re-enable resumes up", int'(link_ok), 1);
        ms(1);
        check("R8 fresh silence count expires", int'(link_ok), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule